// File: doc/BRIEF.md
# Pipeline Squash and Redirect Controller

This controller sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Fetch always continues down the sequential path, so every conditional branch is treated as not taken. Each cycle the controller looks at three things: the branch that resolves in the memory stage, the exception requests raised by individual stages, and a level-sensitive external interrupt. From these it chooses the next-PC source. It also produces one flush bit per stage. A flush bit empties the stage's pipeline register at the next edge, which clears the register-file and memory write enables carried with the instruction. The memory write of an instruction being killed in the memory stage is gated in the same cycle.

When an exception is taken, all instructions older than the faulting one keep going. The faulting instruction and everything younger are killed. The controller saves the faulting PC in an exception-PC register and steers fetch to a fixed handler address, which is set by a parameter. Only one event is honoured per cycle. The choice follows program order: the oldest event wins, and the interrupt ranks below everything else.

The block has no sequential state except the exception-PC register. All redirect and flush outputs are combinational functions of the current cycle's inputs.

Top module: `squash_ctrl`

## Requirements
- R1: After reset, the exception PC reads 0. With no request active, `pc_sel_o` is 0 (sequential), `flush_o` is 0 and `redirect_pc_o` is 0.
- R2: The branch is taken when `br_resolved_i` and `br_taken_i` are both high, and no memory-stage exception is active. In that case `pc_sel_o` = 1 (branch) and `redirect_pc_o` = `br_target_i` in the same cycle. `flush_o` = 4'b0111: bit 0 is fetch, bit 1 decode, bit 2 execute and bit 3 memory, so the three younger stages are killed and the branch itself is kept.
- R3: A resolved branch that is not taken, or `br_taken_i` with `br_resolved_i` low, causes no redirect. In that case `pc_sel_o` = 0 and `flush_o` = 0.
- R4: `mem_we_o` follows `mem_we_i` unless the memory stage is being flushed (`flush_o[3]`). In that case it is 0 in the same cycle.
- R5: A memory-stage exception (`exc_mem_i`) has the highest priority and also beats a taken branch. It gives `pc_sel_o` = 2 (handler) and `flush_o` = 4'b1111. The exception PC equals `mem_pc_i` after the next clock edge.
- R6: An execute-stage overflow (`exc_ex_i`) with no older event gives `pc_sel_o` = 2 and `flush_o` = 4'b0111. The exception PC then takes `ex_pc_i`. A taken branch in the same cycle wins instead.
- R7: A decode-stage illegal instruction (`exc_id_i`) with no older event gives `pc_sel_o` = 2 and `flush_o` = 4'b0011. The exception PC then takes `id_pc_i`. It loses to an execute-stage exception in the same cycle.
- R8: The interrupt (`irq_i`) is taken at the writeback boundary only when no other event is active. When taken, it gives `pc_sel_o` = 2 and `flush_o` = 4'b1111, and the exception PC takes `mem_pc_i`. When any other event is present, the interrupt has no effect that cycle.
- R9: The exception PC changes only on a cycle where `pc_sel_o` = 2. Branch redirects and idle cycles leave it unchanged.
- R10: `redirect_pc_o` equals the parameter `HANDLER_PC` whenever `pc_sel_o` = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_resolved_i | input | 1 | A branch in the memory stage has resolved this cycle |
| br_taken_i | input | 1 | Resolved branch outcome is taken |
| br_target_i | input | AW | Branch target address |
| exc_id_i | input | 1 | Illegal-instruction request from decode |
| exc_ex_i | input | 1 | Arithmetic-overflow request from execute |
| exc_mem_i | input | 1 | Exception request from the memory stage |
| irq_i | input | 1 | External interrupt, level-sensitive |
| id_pc_i | input | AW | PC of the instruction in decode |
| ex_pc_i | input | AW | PC of the instruction in execute |
| mem_pc_i | input | AW | PC of the instruction in memory |
| mem_we_i | input | 1 | Memory write request of the memory-stage instruction |
| pc_sel_o | output | 2 | Next-PC source: 0 sequential, 1 branch target, 2 handler |
| redirect_pc_o | output | AW | Redirect address (0 when sequential) |
| flush_o | output | 4 | Per-stage kill: bit0 fetch, bit1 decode, bit2 execute, bit3 memory |
| mem_we_o | output | 1 | Gated memory write enable |
| epc_o | output | AW | Exception PC register |
| handler_pc_o | output | AW | Fixed handler address |

## Verification
The bench puts simultaneous events together and checks which one wins. One pair is a memory-stage fault with a taken branch. If the priority were wrong, the faulting instruction's store would complete and the faulting PC would never be saved. Other pairs set an execute overflow against a taken branch, and an interrupt against a decode fault. Getting either of these wrong would leave a younger exception able to steal a redirect that belongs to an older instruction. The bench also checks the flush depth of each event, where an off-by-one would kill the branch itself or let a younger instruction through. Finally, it confirms that branch redirects leave the exception PC alone, and that a branch with only the taken bit set causes no redirect.

// File: rtl/squash_pkg.sv
package squash_pkg;
  typedef enum logic [1:0] {
    PCSEL_SEQ     = 2'd0,
    PCSEL_BRANCH  = 2'd1,
    PCSEL_HANDLER = 2'd2
  } pc_sel_e;

  // pipeline stages that can be killed, youngest first
  localparam int NKILL  = 4;
  localparam int KILL_W = $clog2(NKILL);

  localparam logic [KILL_W-1:0] STG_ID  = KILL_W'(1);
  localparam logic [KILL_W-1:0] STG_EX  = KILL_W'(2);
  localparam logic [KILL_W-1:0] STG_MEM = KILL_W'(3);
endpackage

// File: rtl/squash_arbiter.sv
module squash_arbiter
  import squash_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              br_hit,
  input  logic              exc_id,
  input  logic              exc_ex,
  input  logic              exc_mem,
  input  logic              irq,
  input  logic [AW-1:0]     id_pc,
  input  logic [AW-1:0]     ex_pc,
  input  logic [AW-1:0]     mem_pc,
  output pc_sel_e           sel,
  output logic              kill_act,
  output logic [KILL_W-1:0] kill_from,
  output logic [AW-1:0]     epc_next
);
  // program order: memory stage is oldest, then the branch in memory,
  // then execute, then decode; interrupt last.
  always_comb begin
    sel       = PCSEL_SEQ;
    kill_act  = 1'b0;
    kill_from = '0;
    epc_next  = '0;
    if (exc_mem) begin
      sel = PCSEL_HANDLER; kill_act = 1'b1; kill_from = STG_MEM; epc_next = mem_pc;
    end else if (br_hit) begin
      sel = PCSEL_BRANCH;  kill_act = 1'b1; kill_from = STG_EX;
    end else if (exc_ex) begin
      sel = PCSEL_HANDLER; kill_act = 1'b1; kill_from = STG_EX;  epc_next = ex_pc;
    end else if (exc_id) begin
      sel = PCSEL_HANDLER; kill_act = 1'b1; kill_from = STG_ID;  epc_next = id_pc;
    end else if (irq) begin
      sel = PCSEL_HANDLER; kill_act = 1'b1; kill_from = STG_MEM; epc_next = mem_pc;
    end
  end
endmodule

// File: rtl/squash_flush_gen.sv
module squash_flush_gen
  import squash_pkg::*;
(
  input  logic              active,
  input  logic [KILL_W-1:0] kill_from,
  output logic [NKILL-1:0]  flush
);
  // thermometer: every stage at or younger than kill_from is killed
  for (genvar gi = NKILL - 1; gi >= 0; gi--) begin : g_stage
    if (gi == NKILL - 1) begin : g_top
      assign flush[gi] = active && (kill_from == KILL_W'(gi));
    end else begin : g_lower
      assign flush[gi] = flush[gi+1] || (active && (kill_from == KILL_W'(gi)));
    end
  end
endmodule

// File: rtl/squash_epc_reg.sv
module squash_epc_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/squash_ctrl.sv
module squash_ctrl
  import squash_pkg::*;
#(
  parameter int          AW         = 32,
  parameter logic [AW-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_resolved_i,
  input  logic          br_taken_i,
  input  logic [AW-1:0] br_target_i,
  input  logic          exc_id_i,
  input  logic          exc_ex_i,
  input  logic          exc_mem_i,
  input  logic          irq_i,
  input  logic [AW-1:0] id_pc_i,
  input  logic [AW-1:0] ex_pc_i,
  input  logic [AW-1:0] mem_pc_i,
  input  logic          mem_we_i,
  output logic [1:0]    pc_sel_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic [3:0]    flush_o,
  output logic          mem_we_o,
  output logic [AW-1:0] epc_o,
  output logic [AW-1:0] handler_pc_o
);
  pc_sel_e           sel;
  logic              kill_act;
  logic [KILL_W-1:0] kill_from;
  logic [AW-1:0]     epc_next;
  logic [NKILL-1:0]  flush;
  logic              br_hit;

  assign br_hit = br_resolved_i && br_taken_i;

  squash_arbiter #(.AW(AW)) u_arb (
    .br_hit    (br_hit),
    .exc_id    (exc_id_i),
    .exc_ex    (exc_ex_i),
    .exc_mem   (exc_mem_i),
    .irq       (irq_i),
    .id_pc     (id_pc_i),
    .ex_pc     (ex_pc_i),
    .mem_pc    (mem_pc_i),
    .sel       (sel),
    .kill_act  (kill_act),
    .kill_from (kill_from),
    .epc_next  (epc_next)
  );

  squash_flush_gen u_flush (
    .active    (kill_act),
    .kill_from (kill_from),
    .flush     (flush)
  );

  squash_epc_reg #(.AW(AW)) u_epc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sel == PCSEL_HANDLER),
    .d     (epc_next),
    .q     (epc_o)
  );

  always_comb begin
    case (sel)
      PCSEL_BRANCH:  redirect_pc_o = br_target_i;
      PCSEL_HANDLER: redirect_pc_o = HANDLER_PC;
      default:       redirect_pc_o = '0;
    endcase
  end

  assign pc_sel_o     = sel;
  assign flush_o      = flush;
  assign mem_we_o     = mem_we_i && !flush[NKILL-1];
  assign handler_pc_o = HANDLER_PC;
endmodule

// File: rtl/squash_ctrl_chk.sv
module squash_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_resolved_i,
  input logic          br_taken_i,
  input logic          exc_id_i,
  input logic          exc_ex_i,
  input logic          exc_mem_i,
  input logic          irq_i,
  input logic [AW-1:0] mem_pc_i,
  input logic          mem_we_i,
  input logic [1:0]    pc_sel_o,
  input logic [3:0]    flush_o,
  input logic          mem_we_o,
  input logic [AW-1:0] epc_o
);
  p_branch_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_resolved_i && br_taken_i && !exc_mem_i) |-> (pc_sel_o == 2'd1 && flush_o == 4'b0111));

  p_idle_no_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_sel_o == 2'd0) |-> (flush_o == 4'b0000));

  p_mem_we_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o[3] |-> !mem_we_o);

  p_mem_exc_epc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_mem_i |=> (epc_o == $past(mem_pc_i)));

  p_irq_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !exc_mem_i && !exc_ex_i && !exc_id_i && !(br_resolved_i && br_taken_i))
      |-> (pc_sel_o == 2'd2 && flush_o == 4'b1111));

  p_epc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_sel_o != 2'd2) |=> $stable(epc_o));

  p_flush_contiguous_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flush_o + 4'd1));
endmodule

bind squash_ctrl squash_ctrl_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .br_resolved_i (br_resolved_i),
  .br_taken_i    (br_taken_i),
  .exc_id_i      (exc_id_i),
  .exc_ex_i      (exc_ex_i),
  .exc_mem_i     (exc_mem_i),
  .irq_i         (irq_i),
  .mem_pc_i      (mem_pc_i),
  .mem_we_i      (mem_we_i),
  .pc_sel_o      (pc_sel_o),
  .flush_o       (flush_o),
  .mem_we_o      (mem_we_o),
  .epc_o         (epc_o)
);

// File: tb/squash_ctrl_tb.sv
`timescale 1ns/1ps
module squash_ctrl_tb;
  localparam int AW = 32;
  localparam logic [AW-1:0] HPC = 32'h0000_0180;
  localparam logic [AW-1:0] PC_ID  = 32'h0000_1010;
  localparam logic [AW-1:0] PC_EX  = 32'h0000_100C;
  localparam logic [AW-1:0] PC_MEM = 32'h0000_1008;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_resolved_i, br_taken_i, exc_id_i, exc_ex_i, exc_mem_i, irq_i, mem_we_i;
  logic [AW-1:0] br_target_i, id_pc_i, ex_pc_i, mem_pc_i;
  logic [1:0]    pc_sel_o;
  logic [AW-1:0] redirect_pc_o, epc_o, handler_pc_o;
  logic [3:0]    flush_o;
  logic          mem_we_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  squash_ctrl #(.AW(AW), .HANDLER_PC(HPC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .br_resolved_i(br_resolved_i), .br_taken_i(br_taken_i), .br_target_i(br_target_i),
    .exc_id_i(exc_id_i), .exc_ex_i(exc_ex_i), .exc_mem_i(exc_mem_i), .irq_i(irq_i),
    .id_pc_i(id_pc_i), .ex_pc_i(ex_pc_i), .mem_pc_i(mem_pc_i), .mem_we_i(mem_we_i),
    .pc_sel_o(pc_sel_o), .redirect_pc_o(redirect_pc_o), .flush_o(flush_o),
    .mem_we_o(mem_we_o), .epc_o(epc_o), .handler_pc_o(handler_pc_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    br_resolved_i = 0; br_taken_i = 0; br_target_i = '0;
    exc_id_i = 0; exc_ex_i = 0; exc_mem_i = 0; irq_i = 0; mem_we_i = 0;
    id_pc_i = PC_ID; ex_pc_i = PC_EX; mem_pc_i = PC_MEM;
  endtask

  // wait one edge so the register can capture, then sample
  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 epc", epc_o, 0);
    chk("R1 pc_sel", pc_sel_o, 0);
    chk("R1 flush", flush_o, 0);
    chk("R1 redirect", redirect_pc_o, 0);
  endtask

  task automatic t_branch_taken();
    @(negedge clk);
    br_resolved_i = 1; br_taken_i = 1; br_target_i = 32'h0000_2340; mem_we_i = 1;
    #1;
    chk("R2 pc_sel", pc_sel_o, 1);
    chk("R2 redirect", redirect_pc_o, 32'h2340);
    chk("R2 flush", flush_o, 4'b0111);
    chk("R4 mem_we kept", mem_we_o, 1);
    step();
    chk("R9 epc after branch", epc_o, 0);
  endtask

  task automatic t_branch_not_taken();
    @(negedge clk);
    br_resolved_i = 1; br_taken_i = 0; br_target_i = 32'h0000_5550;
    #1;
    chk("R3 nt pc_sel", pc_sel_o, 0);
    chk("R3 nt flush", flush_o, 0);
    br_resolved_i = 0; br_taken_i = 1;
    #1;
    chk("R3 unresolved pc_sel", pc_sel_o, 0);
    chk("R3 unresolved flush", flush_o, 0);
    step();
  endtask

  task automatic t_mem_exc();
    @(negedge clk);
    exc_mem_i = 1; br_resolved_i = 1; br_taken_i = 1; br_target_i = 32'h0000_7770;
    mem_we_i = 1; mem_pc_i = 32'h0000_3008;
    #1;
    chk("R5 pc_sel", pc_sel_o, 2);
    chk("R10 redirect", redirect_pc_o, HPC);
    chk("R5 flush", flush_o, 4'b1111);
    chk("R4 mem_we gated", mem_we_o, 0);
    step();
    chk("R5 epc", epc_o, 32'h3008);
  endtask

  task automatic t_ex_exc();
    @(negedge clk);
    exc_ex_i = 1; ex_pc_i = 32'h0000_400C;
    #1;
    chk("R6 pc_sel", pc_sel_o, 2);
    chk("R6 flush", flush_o, 4'b0111);
    step();
    chk("R6 epc", epc_o, 32'h400C);
    @(negedge clk);
    exc_ex_i = 1; ex_pc_i = 32'h0000_600C;
    br_resolved_i = 1; br_taken_i = 1; br_target_i = 32'h0000_8880;
    #1;
    chk("R6 branch wins", pc_sel_o, 1);
    chk("R6 branch target", redirect_pc_o, 32'h8880);
    step();
    chk("R9 epc kept", epc_o, 32'h400C);
  endtask

  task automatic t_id_exc();
    @(negedge clk);
    exc_id_i = 1; exc_ex_i = 1; id_pc_i = 32'h0000_5010; ex_pc_i = 32'h0000_500C;
    #1;
    chk("R7 ex wins flush", flush_o, 4'b0111);
    step();
    chk("R7 ex wins epc", epc_o, 32'h500C);
    @(negedge clk);
    exc_id_i = 1; id_pc_i = 32'h0000_5110; mem_we_i = 1;
    #1;
    chk("R7 pc_sel", pc_sel_o, 2);
    chk("R7 flush", flush_o, 4'b0011);
    chk("R4 mem_we kept", mem_we_o, 1);
    step();
    chk("R7 epc", epc_o, 32'h5110);
  endtask

  task automatic t_irq();
    @(negedge clk);
    irq_i = 1; mem_pc_i = 32'h0000_9008; mem_we_i = 1;
    #1;
    chk("R8 pc_sel", pc_sel_o, 2);
    chk("R8 flush", flush_o, 4'b1111);
    chk("R8 mem_we gated", mem_we_o, 0);
    chk("R10 redirect", redirect_pc_o, HPC);
    step();
    chk("R8 epc", epc_o, 32'h9008);
    @(negedge clk);
    irq_i = 1; exc_id_i = 1; id_pc_i = 32'h0000_A010;
    #1;
    chk("R8 id wins flush", flush_o, 4'b0011);
    step();
    chk("R8 id wins epc", epc_o, 32'hA010);
    @(negedge clk);
    irq_i = 1; br_resolved_i = 1; br_taken_i = 1; br_target_i = 32'h0000_B000;
    #1;
    chk("R8 branch wins", pc_sel_o, 1);
    step();
    chk("R8 epc unchanged", epc_o, 32'hA010);
    chk("R10 handler port", handler_pc_o, HPC);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_branch_taken();
    t_branch_not_taken();
    t_mem_exc();
    t_ex_exc();
    t_id_exc();
    t_irq();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule